// File: doc/BRIEF.md
# Data-Memory Address Generator with Pointer Indirection

This block turns the operand field of each instruction into addresses for a dual-ported data memory. An operand field of zero selects the indirect data register. In that case the access is redirected to the location held in an internal pointer register. Any other operand is combined with two bank-select bits to form a direct address. The pointer register and the three bank bits live inside the block. They are loaded when an instruction writes file offset 04h (the pointer) or 03h (the status byte). The written data is mirrored into memory as usual, so reads of those offsets stay coherent.

Each instruction is presented for one cycle on a plain instruction stream. Its read address and output enable come out in that same cycle. The operand byte is also returned in that cycle from the asynchronous read port. The matching write address and write enable appear one cycle later, and the result byte is supplied in that cycle. The stream is accepted on every cycle and has no back-pressure. A new instruction may be issued in every cycle, and its read can overlap the previous instruction's write.

The write of the previous instruction is forwarded into the address calculation. As a result, a pointer or bank change is seen by the very next instruction.

Top module: `data_addr_gen`

## Requirements
- R1: When `ins_valid` is high and `ins_opnd` is non-zero, `ram_rd_addr` equals {rp[1:0], ins_opnd[6:0]}. rp[1] is the upper bit.
- R2: When `ins_valid` is high and `ins_opnd` is 00h, `ram_rd_addr` equals {irp, ptr[7:0]}.
- R3: An indirect read whose pointer has bits 6:0 equal to zero does the following. It holds `ram_oe` low and drives `opnd_data` to 00h.
- R4: An indirect write whose pointer has bits 6:0 equal to zero has no effect. `ram_we` stays low in the following cycle, and neither the pointer nor the bank bits change.
- R5: For an instruction with `ins_wr` high that is not suppressed, `ram_we` is high in the next cycle. In that cycle `ram_wr_addr` equals the effective address that instruction used for its read address.
- R6: `ram_oe` is high only when `ins_valid` and `ins_rd` are high. While it is high, `opnd_data` equals `ram_rd_data`; otherwise `opnd_data` is 00h.
- R7: `ram_we` is high only in the cycle after an instruction with `ins_valid` and `ins_wr` high.
- R8: A performed write whose address has bits 6:0 equal to 04h (any bank, direct or indirect) loads `wr_data` into the pointer. The instruction issued in that same cycle already uses the new value.
- R9: A performed write whose address has bits 6:0 equal to 03h loads the bank bits, with the same timing as R8. irp takes `wr_data` bit 7 and rp[1:0] takes bits 6:5.
- R10: Reset clears the pointer and all bank bits, and `ram_we` is low in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_opnd | input | 7 | File operand field of the instruction |
| ins_rd | input | 1 | Instruction reads its file operand |
| ins_wr | input | 1 | Instruction writes its result to the file |
| ram_rd_data | input | 8 | Asynchronous read data from memory |
| wr_data | input | 8 | Result byte of the previous instruction |
| ram_rd_addr | output | 9 | Memory read address |
| ram_oe | output | 1 | Memory output enable |
| opnd_data | output | 8 | Operand byte returned to the datapath |
| ram_wr_addr | output | 9 | Memory write address |
| ram_we | output | 1 | Memory write enable |

## Verification
The following outputs are due in the same cycle the instruction is presented: read address, output enable and the returned operand byte. Write address and write enable are due exactly one cycle later. A pointer or bank update from that write must already shape the address of the instruction issued alongside it. The bench drives each instruction at the falling edge and samples shortly after. At that sample it compares the write outputs against the write it recorded one step earlier. It then applies that write to its own model of the pointer and bank bits before predicting the current read. This reproduces the one-cycle lag and the forwarding rule without looking inside the design.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int OPND_W   = 7;
  localparam int PTR_W    = OPND_W + 1;
  localparam int ADDR_W   = OPND_W + 2;
  localparam int RP_W     = 2;
  localparam int INDF_OFS = 0;
  localparam int STAT_OFS = 3;
  localparam int PTR_OFS  = 4;
  localparam int IRP_POS  = 7;
  localparam int RP_LO    = 5;

  typedef struct packed {
    logic              irp;
    logic [RP_W-1:0]   rp;
    logic [PTR_W-1:0]  ptr;
  } bank_state_t;
endpackage

// File: rtl/dag_bank_regs.sv
module dag_bank_regs
  import dag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PTR_W-1:0]  wr_data,
  output bank_state_t       st_fwd
);
  bank_state_t st_q;
  logic hit_ptr, hit_stat;

  assign hit_ptr  = wr_vld && (wr_addr[OPND_W-1:0] == OPND_W'(PTR_OFS));
  assign hit_stat = wr_vld && (wr_addr[OPND_W-1:0] == OPND_W'(STAT_OFS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      if (hit_ptr) st_q.ptr <= wr_data;
      if (hit_stat) begin
        st_q.irp <= wr_data[IRP_POS];
        st_q.rp  <= wr_data[RP_LO +: RP_W];
      end
    end
  end

  always_comb begin
    st_fwd = st_q;
    if (hit_ptr) st_fwd.ptr = wr_data;
    if (hit_stat) begin
      st_fwd.irp = wr_data[IRP_POS];
      st_fwd.rp  = wr_data[RP_LO +: RP_W];
    end
  end
endmodule

// File: rtl/dag_addr_form.sv
module dag_addr_form
  import dag_pkg::*;
(
  input  logic [OPND_W-1:0] opnd,
  input  bank_state_t       st,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              null_acc
);
  logic indirect;
  assign indirect = (opnd == OPND_W'(INDF_OFS));
  assign eff_addr = indirect ? {st.irp, st.ptr} : {st.rp, opnd};
  assign null_acc = indirect && (st.ptr[OPND_W-1:0] == OPND_W'(INDF_OFS));
endmodule

// File: rtl/dag_write_stage.sv
module dag_write_stage
  import dag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              wr_vld,
  output logic [ADDR_W-1:0] wr_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_vld  <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_vld  <= wr_req;
      wr_addr <= addr_in;
    end
  end
endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen
  import dag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [OPND_W-1:0] ins_opnd,
  input  logic              ins_rd,
  input  logic              ins_wr,
  input  logic [PTR_W-1:0]  ram_rd_data,
  input  logic [PTR_W-1:0]  wr_data,
  output logic [ADDR_W-1:0] ram_rd_addr,
  output logic              ram_oe,
  output logic [PTR_W-1:0]  opnd_data,
  output logic [ADDR_W-1:0] ram_wr_addr,
  output logic              ram_we
);
  bank_state_t       st_fwd;
  logic [ADDR_W-1:0] eff_addr;
  logic              null_acc;
  logic              rd_go, wr_go;

  dag_bank_regs u_bank (
    .clk(clk), .rst_n(rst_n), .wr_vld(ram_we), .wr_addr(ram_wr_addr),
    .wr_data(wr_data), .st_fwd(st_fwd)
  );

  dag_addr_form u_form (
    .opnd(ins_opnd), .st(st_fwd), .eff_addr(eff_addr), .null_acc(null_acc)
  );

  assign rd_go = ins_valid && ins_rd && !null_acc;
  assign wr_go = ins_valid && ins_wr && !null_acc;

  dag_write_stage u_wst (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_go), .addr_in(eff_addr),
    .wr_vld(ram_we), .wr_addr(ram_wr_addr)
  );

  assign ram_rd_addr = eff_addr;
  assign ram_oe      = rd_go;
  assign opnd_data   = rd_go ? ram_rd_data : '0;
endmodule

// File: rtl/data_addr_gen_chk.sv
module data_addr_gen_chk
  import dag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic [OPND_W-1:0] ins_opnd,
  input logic              ins_rd,
  input logic              ins_wr,
  input logic [PTR_W-1:0]  ram_rd_data,
  input logic [ADDR_W-1:0] ram_rd_addr,
  input logic              ram_oe,
  input logic [PTR_W-1:0]  opnd_data,
  input logic [ADDR_W-1:0] ram_wr_addr,
  input logic              ram_we
);
  assert_direct_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_opnd != '0) |-> ram_rd_addr[OPND_W-1:0] == ins_opnd);

  assert_oe_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_oe |-> (ins_valid && ins_rd));

  assert_opnd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe |-> opnd_data == '0);

  assert_opnd_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_oe |-> opnd_data == ram_rd_data);

  assert_we_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) || !ram_we || $past(ins_valid && ins_wr));

  assert_direct_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_wr && ins_opnd != '0) |=> ram_we);

  assert_wr_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_wr && ins_rd && ram_oe) |=>
      (ram_we && ram_wr_addr == $past(ram_rd_addr)));
endmodule

bind data_addr_gen data_addr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_opnd(ins_opnd),
  .ins_rd(ins_rd), .ins_wr(ins_wr), .ram_rd_data(ram_rd_data),
  .ram_rd_addr(ram_rd_addr), .ram_oe(ram_oe), .opnd_data(opnd_data),
  .ram_wr_addr(ram_wr_addr), .ram_we(ram_we)
);

// File: tb/data_addr_gen_bench.sv
module data_addr_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ins_valid = 1'b0;
  logic [6:0] ins_opnd = '0;
  logic       ins_rd = 1'b0;
  logic       ins_wr = 1'b0;
  logic [7:0] ram_rd_data = '0;
  logic [7:0] wr_data = '0;
  logic [8:0] ram_rd_addr;
  logic       ram_oe;
  logic [7:0] opnd_data;
  logic [8:0] ram_wr_addr;
  logic       ram_we;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] m_ptr;
  logic       m_irp;
  logic [1:0] m_rp;
  logic       p_vld;
  logic [8:0] p_addr;

  always #4 clk = ~clk;

  data_addr_gen u_data_addr_gen (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_opnd(ins_opnd),
    .ins_rd(ins_rd), .ins_wr(ins_wr), .ram_rd_data(ram_rd_data),
    .wr_data(wr_data), .ram_rd_addr(ram_rd_addr), .ram_oe(ram_oe),
    .opnd_data(opnd_data), .ram_wr_addr(ram_wr_addr), .ram_we(ram_we)
  );

  function automatic logic [8:0] exp_addr(input logic [6:0] op);
    return (op == 7'h00) ? {m_irp, m_ptr} : {m_rp, op};
  endfunction

  function automatic logic exp_null(input logic [6:0] op);
    return (op == 7'h00) && (m_ptr[6:0] == 7'h00);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [6:0] op, input logic rd,
                      input logic wr, input logic [7:0] rdat, input logic [7:0] wdat);
    logic nl;
    logic [8:0] ea;
    @(negedge clk);
    ins_valid = v; ins_opnd = op; ins_rd = rd; ins_wr = wr;
    ram_rd_data = rdat; wr_data = wdat;
    #2;
    // write stage of previous instruction (R5, R7, R4)
    check("R7 we", ram_we, p_vld);
    if (p_vld) check("R5 wr_addr", ram_wr_addr, p_addr);
    // apply pending write to model, forwarding rule (R8, R9)
    if (p_vld && p_addr[6:0] == 7'h04) m_ptr = wdat;
    if (p_vld && p_addr[6:0] == 7'h03) begin m_irp = wdat[7]; m_rp = wdat[6:5]; end
    ea = exp_addr(op);
    nl = exp_null(op);
    if (v) begin
      if (op == 7'h00) check("R2 R8 R9 rd_addr", ram_rd_addr, ea);
      else             check("R1 R9 rd_addr", ram_rd_addr, ea);
    end
    check(nl ? "R3 oe" : "R6 oe", ram_oe, v && rd && !nl);
    check(nl ? "R3 opnd" : "R6 opnd", opnd_data, (v && rd && !nl) ? rdat : 8'h00);
    p_vld  = v && wr && !nl;
    p_addr = ea;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    m_ptr = 0; m_irp = 0; m_rp = 0; p_vld = 0; p_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R10: reset state, pointer zero makes an indirect read null
    step(1, 7'h00, 1, 1, 8'hAA, 8'h00);
    check("R10 null after reset", ram_oe, 1'b0);
    // R4: the suppressed write must not reach memory or the pointer
    step(1, 7'h10, 1, 0, 8'h11, 8'h55);
    check("R4 no we", ram_we, 1'b0);
    // R8: load pointer with 0x85 then read indirectly in the next cycle
    step(1, 7'h04, 0, 1, 8'h00, 8'h00);
    step(1, 7'h00, 1, 0, 8'h3C, 8'h85);
    check("R8 forwarded ptr", ram_rd_addr, 9'h085);
    // R9: status write 0xE0 -> irp=1 rp=3
    step(1, 7'h03, 0, 1, 8'h00, 8'h00);
    step(1, 7'h21, 1, 1, 8'h77, 8'hE0);
    check("R9 rp forwarded", ram_rd_addr, 9'h1A1);
    step(1, 7'h00, 1, 0, 8'h99, 8'h00);
    check("R9 irp", ram_rd_addr, 9'h185);
    // R4: pointer 0x80 -> indirect target offset 00h, write suppressed
    step(1, 7'h04, 0, 1, 8'h00, 8'h00);
    step(1, 7'h00, 1, 1, 8'h42, 8'h80);
    check("R3 null read", opnd_data, 8'h00);
    step(1, 7'h05, 1, 0, 8'h12, 8'hFF);
    check("R4 suppressed", ram_we, 1'b0);
    step(0, 7'h00, 0, 0, 8'h00, 8'h00);
    // R6: not valid -> nothing
    step(0, 7'h15, 1, 1, 8'h66, 8'h00);
    check("R6 idle oe", ram_oe, 1'b0);
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] op;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1: op = 7'h00;
        2:    op = 7'h03;
        3:    op = 7'h04;
        default: op = 7'($urandom_range(0, 127));
      endcase
      step($urandom_range(0, 7) != 0, op, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
           (sel == 9) ? 8'($urandom_range(0, 1) << 7) : 8'($urandom_range(0, 255)));
    end
    step(0, 7'h00, 0, 0, 8'h00, 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule